// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block sits between the address-latch logic of a word-organised memory and its output bus. It orders and times the words of a synchronous burst read. A strobe captures a start address and a set of configuration fields. The block then waits a programmable number of clock cycles and presents one word per clock, or one word every two clocks. While it does so it produces the sequence of array addresses and a read request for each word.

A burst is four words, eight words or continuous. Four- and eight-word bursts wrap inside their aligned group, in linear or interleaved order. A continuous burst counts upward until the last word of the current bank and then stops. In continuous mode, a start address that is not a multiple of four makes the block pause once, on the first crossing of a 32-word boundary. A WAIT output marks the pause, either during it or one cycle ahead of it. The active clock edge can be the rising or the falling edge of the input clock.

Top module: `burst_read_seq`

## Requirements
- R1: While reset is asserted, and after reset until the first strobe, `dvalid_o`, `wait_o` and `arr_req_o` are 0.
- R2: With `load` high at an active edge k, the configuration is captured at that edge. The first word is visible after edge k+L, where L is the binary value of `cfg_latency`. L is 2 to 6, and 5 or 6 only when `cfg_half_rate` is 1.
- R3: `cfg_len` = 00 selects 4 words and 01 selects 8 words. Word n uses the aligned group of the start address, with low bits (start + n) mod N. After N words `dvalid_o` returns to 0. `dout_o` changes only at an edge that follows an `arr_req_o` cycle.
- R4: With `cfg_interleave` = 1, the low bits of word n of a 4- or 8-word burst are start XOR n. In continuous mode the bit has no effect.
- R5: With `cfg_half_rate` = 1, every word stays on `dout_o` with `dvalid_o` high for two cycles, and array requests are never on consecutive cycles.
- R6: `cfg_len` = 1x selects continuous mode, with words at start, start+1, and so on. Let o be start[1:0]. If o is not 0, then before the first word whose address is a multiple of 32 (other than the start), there are o cycles (2*o in half rate) with `dvalid_o` = 0 and `wait_o` = 1.
- R7: A continuous burst whose start[1:0] = 0 has no wait cycles. No burst waits more than once.
- R8: A continuous burst ends after the word whose low BANK_W address bits are all ones. It never continues into the next bank.
- R9: With `cfg_wait_early` = 1, the wait indication has the same length but starts and ends one cycle earlier.
- R10: A strobe during a burst abandons it. `dvalid_o` is 0 in the following cycle, and the new burst follows R2 from that edge.
- R11: With `cfg_falling_edge` = 1, all state advances on the falling edge of `clk`. This bit may change only while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Start-address strobe, sampled at the active edge |
| start_addr | input | ADDR_W | Word address of the first beat |
| cfg_latency | input | 3 | Initial latency in cycles (2..6) |
| cfg_len | input | 2 | 00 = 4 words, 01 = 8 words, 1x = continuous |
| cfg_interleave | input | 1 | 1 = interleaved order for wrapped bursts |
| cfg_half_rate | input | 1 | 1 = one word every two cycles |
| cfg_wait_early | input | 1 | 1 = WAIT leads the pause by one cycle |
| cfg_falling_edge | input | 1 | 1 = active edge is the falling edge of clk |
| arr_req_o | output | 1 | Array read request for the current address |
| arr_addr_o | output | ADDR_W | Array word address |
| arr_data | input | DATA_W | Array read data, valid in the request cycle |
| dout_o | output | DATA_W | Burst output word |
| dvalid_o | output | 1 | Output word is valid in this cycle |
| wait_o | output | 1 | Wait indication |

## Verification
The embedded checks rely on two input conditions. Every strobe must carry a legal latency: 2 to 6, with 5 or 6 only in half-rate mode. The edge-select bit must change only while reset is low. The bench meets both. It chooses latencies from the legal set for each rate, and it changes the edge selection only inside a reset pulse. It also assumes that the array data is a pure function of the address in the same cycle, and its array model supplies exactly that.

// File: rtl/burst_read_seq.sv
module burst_read_seq #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int BANK_W = 8,
  parameter int GAP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [2:0]        cfg_latency,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_interleave,
  input  logic              cfg_half_rate,
  input  logic              cfg_wait_early,
  input  logic              cfg_falling_edge,
  output logic              arr_req_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] dout_o,
  output logic              dvalid_o,
  output logic              wait_o
);
  localparam logic [ADDR_W-1:0] MASK4 = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] MASK8 = ADDR_W'(7);

  logic              eff_clk;
  logic              active_q, started_q, more_q, waited_q;
  logic              cont_q, len8_q, il_q, hr_q, early_q;
  logic [ADDR_W-1:0] start_q, beat_q;
  logic [GAP_W-1:0]  gap_q, wlen_q;

  logic [ADDR_W-1:0] mask, lin, cur_addr, nxt_addr;
  logic [1:0]        off;
  logic              present, last, need_wait, stall, early_stall;
  logic [GAP_W-1:0]  hold, wait_len;

  assign eff_clk  = clk ^ cfg_falling_edge;
  assign mask     = len8_q ? MASK8 : MASK4;
  assign lin      = start_q + beat_q;
  assign cur_addr = cont_q ? lin
                  : ((start_q & ~mask) | ((il_q ? (start_q ^ beat_q) : lin) & mask));
  assign nxt_addr = cur_addr + ADDR_W'(1);
  assign off      = start_q[1:0];
  assign present  = active_q && more_q && (gap_q == '0);
  assign last     = cont_q ? (&cur_addr[BANK_W-1:0]) : (beat_q == (len8_q ? MASK8 : MASK4));
  assign need_wait = cont_q && (off != 2'd0) && !waited_q && !last && (nxt_addr[4:0] == 5'd0);
  assign hold     = hr_q ? GAP_W'(2) : GAP_W'(1);
  assign wait_len = !need_wait ? '0 : (hr_q ? GAP_W'({off, 1'b0}) : GAP_W'(off));

  assign stall       = more_q && (gap_q < wlen_q);
  assign early_stall = more_q && (gap_q != '0) && (gap_q <= wlen_q);

  assign arr_req_o  = present;
  assign arr_addr_o = cur_addr;
  assign dvalid_o   = active_q && started_q && !stall;
  assign wait_o     = active_q && (early_q ? early_stall : stall);

  always_ff @(posedge eff_clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      started_q <= 1'b0;
      more_q    <= 1'b0;
      waited_q  <= 1'b0;
      cont_q    <= 1'b0;
      len8_q    <= 1'b0;
      il_q      <= 1'b0;
      hr_q      <= 1'b0;
      early_q   <= 1'b0;
      start_q   <= '0;
      beat_q    <= '0;
      gap_q     <= '0;
      wlen_q    <= '0;
      dout_o    <= '0;
    end else if (load) begin
      active_q  <= 1'b1;
      started_q <= 1'b0;
      more_q    <= 1'b1;
      waited_q  <= 1'b0;
      cont_q    <= cfg_len[1];
      len8_q    <= (cfg_len == 2'b01);
      il_q      <= cfg_interleave;
      hr_q      <= cfg_half_rate;
      early_q   <= cfg_wait_early;
      start_q   <= start_addr;
      beat_q    <= '0;
      gap_q     <= GAP_W'(cfg_latency) - GAP_W'(1);
      wlen_q    <= '0;
    end else if (present) begin
      dout_o    <= arr_data;
      started_q <= 1'b1;
      beat_q    <= beat_q + ADDR_W'(1);
      more_q    <= !last;
      waited_q  <= waited_q | need_wait;
      wlen_q    <= wait_len;
      gap_q     <= hold - GAP_W'(1) + wait_len;
    end else if (active_q && gap_q != '0) begin
      gap_q <= gap_q - GAP_W'(1);
    end else if (active_q && !more_q) begin
      active_q  <= 1'b0;
      started_q <= 1'b0;
    end
  end

  a_r2_legal_latency: assert property (@(posedge eff_clk) disable iff (!rst_n)
    load |-> (cfg_latency >= 3'd2 && cfg_latency <= 3'd6 && (cfg_latency <= 3'd4 || cfg_half_rate)));

  a_r10_load_blanks: assert property (@(posedge eff_clk) disable iff (!rst_n)
    load |=> (!dvalid_o && !wait_o));

  a_r6_wait_needs_offset: assert property (@(posedge eff_clk) disable iff (!rst_n)
    wait_o |-> (cont_q && start_q[1:0] != 2'd0));

  a_r5_half_rate_spacing: assert property (@(posedge eff_clk) disable iff (!rst_n)
    (arr_req_o && hr_q) |=> !arr_req_o);

  a_r3_dout_changes_on_fetch: assert property (@(posedge eff_clk) disable iff (!rst_n)
    !$past(arr_req_o) |-> $stable(dout_o));
endmodule

// File: tb/burst_read_seq_tb.sv
`timescale 1ns/1ps
module burst_read_seq_tb_top;
  localparam int AW = 12;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [2:0] cfg_latency = 3'd2;
  logic [1:0] cfg_len = 2'b00;
  logic cfg_interleave = 1'b0, cfg_half_rate = 1'b0, cfg_wait_early = 1'b0, cfg_falling_edge = 1'b0;
  logic arr_req_o, dvalid_o, wait_o;
  logic [AW-1:0] arr_addr_o;
  logic [DW-1:0] arr_data, dout_o;
  logic eff_clk;

  int errors = 0, checks = 0;
  string tag = "R1";
  int ev[$], ew[$];
  logic [DW-1:0] ed[$];

  always #10 clk = ~clk;
  assign eff_clk = clk ^ cfg_falling_edge;

  function automatic logic [DW-1:0] mem(input logic [AW-1:0] a);
    return DW'(a) * 16'd37 + 16'h1234;
  endfunction
  assign arr_data = mem(arr_addr_o);

  burst_read_seq dut_i (
    .clk(clk), .rst_n(rst_n), .load(load), .start_addr(start_addr),
    .cfg_latency(cfg_latency), .cfg_len(cfg_len), .cfg_interleave(cfg_interleave),
    .cfg_half_rate(cfg_half_rate), .cfg_wait_early(cfg_wait_early),
    .cfg_falling_edge(cfg_falling_edge), .arr_req_o(arr_req_o), .arr_addr_o(arr_addr_o),
    .arr_data(arr_data), .dout_o(dout_o), .dvalid_o(dvalid_o), .wait_o(wait_o));

  task automatic build();
    int h, n, o, nw, s;
    bit cont, waited;
    logic [AW-1:0] a, nx;
    ev.delete(); ew.delete(); ed.delete();
    h = cfg_half_rate ? 2 : 1;
    cont = cfg_len[1];
    nw = (cfg_len == 2'b01) ? 8 : 4;
    s = int'(start_addr);
    o = s % 4;
    waited = 0;
    for (int i = 0; i < int'(cfg_latency); i++) begin ev.push_back(0); ew.push_back(0); ed.push_back('0); end
    n = 0;
    forever begin
      if (cont) a = AW'(s + n);
      else if (cfg_interleave) a = AW'(s - s % nw + ((s % nw) ^ n));
      else a = AW'(s - s % nw + (s % nw + n) % nw);
      for (int i = 0; i < h; i++) begin ev.push_back(1); ew.push_back(0); ed.push_back(mem(a)); end
      if (cont ? (int'(a) % 256 == 255) : (n == nw - 1)) break;
      nx = a + 1'b1;
      if (cont && o != 0 && !waited && int'(nx) % 32 == 0) begin
        for (int i = 0; i < o * h; i++) begin ev.push_back(0); ew.push_back(1); ed.push_back('0); end
        waited = 1;
      end
      n++;
    end
    if (cfg_wait_early) begin
      for (int i = 0; i < ew.size() - 1; i++) ew[i] = ew[i + 1];
      ew[ew.size() - 1] = 0;
    end
  endtask

  task automatic compare();
    int v = 0, w = 0;
    logic [DW-1:0] d = '0;
    if (ev.size() > 0) begin v = ev.pop_front(); w = ew.pop_front(); d = ed.pop_front(); end
    checks++;
    if (dvalid_o !== 1'(v) || wait_o !== 1'(w) || (v == 1 && dout_o !== d)) begin
      errors++;
      $display("FAIL %s dvalid/wait/data got %b/%b/%h exp %0d/%0d/%h at %0t",
               tag, dvalid_o, wait_o, dout_o, v, w, d, $time);
    end
  endtask

  task automatic tick();
    logic was_load;
    was_load = load;
    @(posedge eff_clk); #5;
    if (was_load) build();
    compare();
  endtask

  task automatic burst(input logic [AW-1:0] a, input int lat, input logic [1:0] len,
                       input bit il, input bit hr, input bit early, input int stop_after);
    start_addr = a; cfg_latency = 3'(lat); cfg_len = len;
    cfg_interleave = il; cfg_half_rate = hr; cfg_wait_early = early;
    load = 1'b1;
    tick();
    load = 1'b0;
    if (stop_after > 0) begin
      for (int i = 0; i < stop_after; i++) tick();
    end else begin
      while (ev.size() > 0) tick();
      tick(); tick();
    end
  endtask

  task automatic do_reset(input bit falling);
    rst_n = 1'b0;
    ev.delete(); ew.delete(); ed.delete();
    #7 cfg_falling_edge = falling;
    @(posedge eff_clk); #5;
    checks++;
    if (dvalid_o !== 1'b0 || wait_o !== 1'b0 || arr_req_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 in reset dvalid/wait/req got %b/%b/%b exp 0/0/0", dvalid_o, wait_o, arr_req_o);
    end
    rst_n = 1'b1;
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    tag = "R1";
    for (int i = 0; i < 3; i++) begin
      tick();
      checks++;
      if (arr_req_o !== 1'b0) begin errors++; $display("FAIL R1 arr_req got %b exp 0", arr_req_o); end
    end
    tag = "R2 R3 linear 4";        burst(12'h012, 3, 2'b00, 0, 0, 0, 0);
    tag = "R2 R3 linear 8";        burst(12'h035, 2, 2'b01, 0, 0, 0, 0);
    tag = "R4 interleaved 8";      burst(12'h0A5, 4, 2'b01, 1, 0, 0, 0);
    tag = "R4 interleaved 4";      burst(12'h003, 2, 2'b00, 1, 0, 0, 0);
    tag = "R5 half rate 4";        burst(12'h021, 5, 2'b00, 0, 1, 0, 0);
    tag = "R5 half rate 8 il";     burst(12'h046, 6, 2'b01, 1, 1, 0, 0);
    tag = "R6 R8 cont offset 3";   burst(12'h03B, 3, 2'b10, 0, 0, 0, 0);
    tag = "R6 R7 cont offset 1";   burst(12'h121, 2, 2'b11, 1, 0, 0, 0);
    tag = "R7 R8 R4 cont aligned"; burst(12'h240, 4, 2'b10, 1, 0, 0, 0);
    tag = "R6 R9 early half rate"; burst(12'h31E, 6, 2'b10, 0, 1, 1, 0);
    tag = "R9 early full rate";    burst(12'h4DA, 2, 2'b10, 0, 0, 1, 0);
    tag = "R8 bank end no wait";   burst(12'h1FD, 3, 2'b10, 0, 0, 0, 0);
    tag = "R10 abort in latency";  burst(12'h050, 4, 2'b01, 0, 0, 0, 2);
    tag = "R10 abort mid burst";   burst(12'h07D, 2, 2'b10, 0, 0, 0, 5);
    tag = "R10 restart";           burst(12'h0C2, 3, 2'b00, 1, 0, 0, 0);
    do_reset(1'b1);
    tag = "R11 falling edge";      burst(12'h016, 3, 2'b01, 0, 0, 0, 0);
    tag = "R11 falling cont";      burst(12'h5E2, 5, 2'b10, 0, 1, 1, 0);
    do_reset(1'b0);
    tag = "R11 back to rising";    burst(12'h00A, 2, 2'b00, 0, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule